// File: doc/BRIEF.md
# Display Event Interrupt Controller

This block gathers single-cycle event pulses from a raster display pipeline into a status register. Software reaches the register through a small register port. Two views of the status are available. The raw view shows every event that has been recorded. The masked view shows only the events whose enable bit is set. Software clears a status bit by writing a one to it, and it may write to either view. The enable mask is changed through two addresses. One address sets bits and the other clears them. Reading either address returns the mask.

A three-state machine drives the single interrupt line:
- **ST_ARMED**: the line is low and waits for a pending masked event.
- **ST_ACTIVE**: the line is high.
- **ST_SPENT**: the line is low, and new events cannot raise it.

The transitions are:
- **fire** (ARMED→ACTIVE): taken when the masked status is nonzero.
- **ack** (ACTIVE→ARMED): taken on an end-of-interrupt write.
- **drain** (ACTIVE→SPENT): taken when the masked status falls to zero with no end-of-interrupt write.
- **rearm** (SPENT→ARMED): taken on an end-of-interrupt write.

In every other case the state holds. A separate level output reports a loss of synchronisation. It is high when the sync-lost and underflow bits are both recorded, and it stays high until software clears one of them.

Top module: `disp_evt_irq`

## Requirements
- R1: An event pulse on an implemented bit sets the matching raw status bit after the clock edge on which it arrives. The implemented bits are: bit 0 frame-done, bit 2 sync-lost, bit 5 underflow, bit 6 palette-loaded, bit 8 end of frame for buffer 0, and bit 9 end of frame for buffer 1. The raw view reads at address 0.
- R2: Bits 1, 3, 4, 7 and every bit from 10 upward read as zero in the status, the mask and both views. Events and writes do not change them.
- R3: Writing address 0 (raw) or address 1 (masked) clears each status bit written as one. A bit written as zero is unchanged.
- R4: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: Address 1 reads the raw status ANDed with the enable mask.
- R6: A write to address 2 ORs the written bits into the mask. A write to address 3 removes the written bits from the mask. Reading either address returns the mask.
- R7: In ST_ARMED, a nonzero masked status raises irq_o one clock edge after the masked status becomes nonzero.
- R8: Once irq_o has asserted, it cannot assert again until software writes any value to address 4 (end of interrupt). irq_o falls one edge after the masked status becomes zero. An end-of-interrupt write while the line is high drops it for one cycle, and the line rises again if the masked status is still nonzero.
- R9: sync_fault_o is high exactly while raw bit 2 and raw bit 5 are both set.
- R10: After reset, the status and mask are zero, the machine is in ST_ARMED, and irq_o and sync_fault_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 10 | Event pulses, one bit per status position |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 raw, 1 masked, 2 enable-set, 3 enable-clear, 4 end of interrupt) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Interrupt line |
| sync_fault_o | output | 1 | Loss-of-synchronisation level |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 3. With these values the ten-bit status has six live bits. This makes it practical to pulse every bit position one at a time and to sweep all 64 enable-mask combinations. For each combination the bench checks the read-back of both enable addresses, the masked view and the interrupt line. The bench also runs directed sequences for the event-versus-clear collision, the SPENT hold and end-of-interrupt rearm, and the sync-fault pairing.

// File: rtl/disp_evt_pkg.sv
package disp_evt_pkg;
    localparam int STAT_W = 10;
    localparam logic [STAT_W-1:0] IMPL_BITS = 10'b11_0110_0101;

    localparam int BIT_FRAME_DONE = 0;
    localparam int BIT_SYNC_LOST  = 2;
    localparam int BIT_UNDERFLOW  = 5;
    localparam int BIT_PAL_LOADED = 6;
    localparam int BIT_EOF_BUF0   = 8;
    localparam int BIT_EOF_BUF1   = 9;

    localparam int RA_RAW    = 0;
    localparam int RA_MASKED = 1;
    localparam int RA_EN_SET = 2;
    localparam int RA_EN_CLR = 3;
    localparam int RA_EOI    = 4;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SPENT  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/disp_evt_status.sv
module disp_evt_status
    import disp_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic [STAT_W-1:0] w1c_i,
    input  logic [STAT_W-1:0] en_set_i,
    input  logic [STAT_W-1:0] en_clr_i,
    output logic [STAT_W-1:0] raw_o,
    output logic [STAT_W-1:0] mask_o
);
    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] mask_q;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_live
            // event has priority over a same-cycle clear (R4)
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    raw_q[i]  <= 1'b0;
                    mask_q[i] <= 1'b0;
                end else begin
                    raw_q[i]  <= evt_i[i] | (raw_q[i] & ~w1c_i[i]);
                    mask_q[i] <= en_set_i[i] | (mask_q[i] & ~en_clr_i[i]);
                end
            end
        end else begin : g_dead
            assign raw_q[i]  = 1'b0;
            assign mask_q[i] = 1'b0;
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/disp_evt_arm_fsm.sv
module disp_evt_arm_fsm
    import disp_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eoi_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  if (pend_i) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (eoi_i)        state_d = ST_ARMED;
                else if (!pend_i) state_d = ST_SPENT;
            end
            ST_SPENT:  if (eoi_i) state_d = ST_ARMED;
            default:   state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_ACTIVE);
    end
endmodule

// File: rtl/disp_evt_irq.sv
module disp_evt_irq
    import disp_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              sync_fault_o
);
    logic [STAT_W-1:0] wbits;
    logic [STAT_W-1:0] w1c;
    logic [STAT_W-1:0] en_set;
    logic [STAT_W-1:0] en_clr;
    logic [STAT_W-1:0] raw_w;
    logic [STAT_W-1:0] mask_w;
    logic [STAT_W-1:0] masked_w;
    logic              eoi;
    logic              sel_raw, sel_msk, sel_set, sel_clr, sel_eoi;

    assign sel_raw = (reg_addr_i == ADDR_W'(RA_RAW));
    assign sel_msk = (reg_addr_i == ADDR_W'(RA_MASKED));
    assign sel_set = (reg_addr_i == ADDR_W'(RA_EN_SET));
    assign sel_clr = (reg_addr_i == ADDR_W'(RA_EN_CLR));
    assign sel_eoi = (reg_addr_i == ADDR_W'(RA_EOI));

    assign wbits  = reg_wdata_i[STAT_W-1:0];
    assign w1c    = (reg_wr_i && (sel_raw || sel_msk)) ? wbits : '0;
    assign en_set = (reg_wr_i && sel_set) ? wbits : '0;
    assign en_clr = (reg_wr_i && sel_clr) ? wbits : '0;
    assign eoi    = reg_wr_i && sel_eoi;

    disp_evt_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .w1c_i    (w1c),
        .en_set_i (en_set),
        .en_clr_i (en_clr),
        .raw_o    (raw_w),
        .mask_o   (mask_w)
    );

    assign masked_w = raw_w & mask_w;

    disp_evt_arm_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (|masked_w),
        .eoi_i  (eoi),
        .irq_o  (irq_o)
    );

    assign sync_fault_o = raw_w[BIT_SYNC_LOST] & raw_w[BIT_UNDERFLOW];

    always_comb begin
        reg_rdata_o = '0;
        if (sel_raw)                reg_rdata_o = DATA_W'(raw_w);
        else if (sel_msk)           reg_rdata_o = DATA_W'(masked_w);
        else if (sel_set || sel_clr) reg_rdata_o = DATA_W'(mask_w);
    end
endmodule

// File: rtl/disp_evt_chk.sv
module disp_evt_chk
    import disp_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic              irq_o,
    input logic [STAT_W-1:0] raw,
    input logic [STAT_W-1:0] mask
);
    logic              eoi_wr;
    logic              need_eoi_q;
    logic [STAT_W-1:0] wb;

    assign eoi_wr = reg_wr_i && (reg_addr_i == ADDR_W'(RA_EOI));
    assign wb     = reg_wdata_i[STAT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      need_eoi_q <= 1'b0;
        else if (eoi_wr) need_eoi_q <= 1'b0;
        else if (irq_o)  need_eoi_q <= 1'b1;
    end

    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & IMPL_BITS)) |=>
        ((raw & $past(evt_i & IMPL_BITS)) == $past(evt_i & IMPL_BITS)));

    assert_dead_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~IMPL_BITS) == '0) && ((mask & ~IMPL_BITS) == '0));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(RA_RAW)) && (evt_i == '0)) |=>
        ((raw & $past(wb)) == '0));

    assert_en_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(RA_EN_SET))) |=>
        ((mask & $past(wb) & IMPL_BITS) == ($past(wb) & IMPL_BITS)));

    assert_en_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(RA_EN_CLR))) |=>
        ((mask & $past(wb)) == '0));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(raw & mask)));

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(need_eoi_q));
endmodule

bind disp_evt_irq disp_evt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .raw         (raw_w),
    .mask        (mask_w)
);

// File: tb/sim_disp_evt_irq.sv
module sim_disp_evt_irq;
    import disp_evt_pkg::*;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [STAT_W-1:0] evt = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq, sync_fault;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    disp_evt_irq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq), .sync_fault_o(sync_fault));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [STAT_W-1:0] b);
        evt = b;
        tick();
        evt = '0;
    endtask

    task automatic quiesce();
        wr(RA_EN_CLR, '1);
        wr(RA_RAW, '1);
        tick();
        wr(RA_EOI, 0);
    endtask

    function automatic logic [STAT_W-1:0] expand(input logic [5:0] m);
        logic [STAT_W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < STAT_W; i++) begin
            if (IMPL_BITS[i]) begin
                r[i] = m[k];
                k++;
            end
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [STAT_W-1:0] e;
        repeat (3) @(negedge clk);
        // R10 reset state
        rd(RA_RAW, d);   chk("R10 raw", d, 0);
        rd(RA_EN_SET, d); chk("R10 mask", d, 0);
        chk("R10 irq", irq, 0);
        chk("R10 sync", sync_fault, 0);
        rst_n = 1'b1;
        tick();

        // R1 / R2 per-bit sweep
        for (int i = 0; i < STAT_W; i++) begin
            pulse(STAT_W'(1) << i);
            rd(RA_RAW, d);
            chk("R1 R2 single event", d, 32'(IMPL_BITS & (STAT_W'(1) << i)));
            chk("R7 no irq while masked off", irq, 0);
            wr(RA_RAW, '1);
            rd(RA_RAW, d); chk("R3 clear all", d, 0);
        end

        // R3 zero leaves, masked view clears raw
        pulse(10'h101);
        wr(RA_RAW, 0);
        rd(RA_RAW, d); chk("R3 zero write keeps", d, 32'h101);
        wr(RA_MASKED, 32'h100);
        rd(RA_RAW, d); chk("R3 masked-view clear", d, 32'h001);
        wr(RA_RAW, '1);

        // R5 R6 R7 mask sweep
        for (int m = 0; m < 64; m++) begin
            e = expand(6'(m));
            quiesce();
            wr(RA_EN_SET, 32'(e));
            rd(RA_EN_SET, d); chk("R6 set readback", d, 32'(e));
            rd(RA_EN_CLR, d); chk("R6 clr readback", d, 32'(e));
            pulse(IMPL_BITS);
            rd(RA_MASKED, d); chk("R5 masked view", d, 32'(e));
            rd(RA_RAW, d); chk("R1 raw all", d, 32'(IMPL_BITS));
            chk("R7 irq not yet", irq, 0);
            tick();
            chk("R7 irq level", irq, 32'(e != 0));
        end

        // R6 partial clear and OR
        quiesce();
        wr(RA_EN_SET, 32'h300);
        wr(RA_EN_CLR, 32'h100);
        rd(RA_EN_SET, d); chk("R6 clear-enable", d, 32'h200);
        wr(RA_EN_SET, 32'h004);
        rd(RA_EN_SET, d); chk("R6 set ORs", d, 32'h204);
        // R2 unused bits
        wr(RA_EN_SET, '1);
        rd(RA_EN_CLR, d); chk("R2 mask dead bits", d, 32'(IMPL_BITS));
        pulse('1);
        rd(RA_MASKED, d); chk("R2 masked dead bits", d, 32'(IMPL_BITS));

        // R8 end-of-interrupt sequencing
        quiesce();
        wr(RA_EN_SET, 32'h100);
        pulse(10'h100);
        tick();
        chk("R8 first assert", irq, 1);
        wr(RA_MASKED, 32'h100);
        chk("R8 still high one edge", irq, 1);
        tick();
        chk("R8 drops when drained", irq, 0);
        pulse(10'h100);
        tick(); tick();
        chk("R8 held off without eoi", irq, 0);
        wr(RA_EOI, 32'h5A);
        chk("R8 rearm edge", irq, 0);
        tick();
        chk("R8 reassert after eoi", irq, 1);
        wr(RA_EOI, 0);
        chk("R8 eoi drops line", irq, 0);
        tick();
        chk("R8 rises again pending", irq, 1);

        // R4 collision
        quiesce();
        pulse(10'h001);
        evt = 10'h200;
        wr(RA_RAW, 32'h201);
        evt = '0;
        rd(RA_RAW, d); chk("R4 event beats clear", d, 32'h200);

        // R9 sync fault
        wr(RA_RAW, '1);
        pulse(10'h004);
        chk("R9 sync-lost alone", sync_fault, 0);
        pulse(10'h020);
        chk("R9 both set", sync_fault, 1);
        wr(RA_RAW, 32'h004);
        chk("R9 cleared", sync_fault, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule